// File: doc/BRIEF.md
# Eight-Bit ALU with Status Register

This block is the arithmetic and logic datapath of a small eight-bit processor core. Each cycle it takes a destination operand, a source operand, the high byte of a register pair, the index of the destination register and an operation code. It returns the value to be written back, the high byte for word operations, and a per-operation mask of the status bits that the operation updates. The status register is held inside the block. Its carry bit feeds the carry-using operations, and its zero bit feeds the chained subtract and compare operations.

Register file, instruction decode and memory sit outside this block. The caller writes back the result. For operations that update no status bit, and for copies and loads, the status register keeps its previous value. This lets software move data without disturbing the flags left by an earlier test. Two word operations add or subtract a small unsigned immediate on a register pair. The block checks that the destination index names one of the permitted pairs.

Top module: `alu8_core`

## Requirements
- R1: After reset the status register reads 0x00. Its bit positions are carry 0, zero 1, negative 2, overflow 3, signed-test 4, half-carry 5, user bit T 6, interrupt enable I 7.
- R2: Add (5), add with carry (6), subtract (7) and compare (9) update C, Z, N, V, S and H (mask 0x3F). C is the carry out of bit 7, or the borrow for subtract and compare. H is the carry out of bit 3, or the borrow for subtract and compare. V is two's-complement overflow and S = N xor V. Compare returns operand A unchanged. Increment (12) and decrement (13) update only Z, N, V and S (mask 0x1E).
- R3: Subtract with carry (8) and compare with carry (10) subtract B plus carry. A zero difference leaves Z at its previous value, and a non-zero difference clears Z. The other flags follow R2.
- R4: No-op (0), copy (1, result = B), load constant (2, result = B), fill (3, result 0xFF) and nibble swap (4) leave every status bit unchanged. Their mask is 0x00. Opcodes 29 to 31 also act as no-ops.
- R5: Shift left (20) and rotate left through carry (22) move bit 7 into C and copy bit 3 into H (mask 0x3F). Shift right (21), rotate right through carry (23) and arithmetic shift right (24) move bit 0 into C (mask 0x1F). Rotates shift the old C in. Arithmetic shift right keeps bit 7. For all shifts V = N xor C.
- R6: Nibble swap (4) returns {A[3:0], A[7:4]}.
- R7: Clear (19) is A xor A. The result is 0x00, Z is set, N, V and S are cleared, and C and H are unchanged (mask 0x1E).
- R8: AND (14), OR (15), XOR (16) and test (17, result = A, flags from A) clear V and update Z, N and S (mask 0x1E). One's complement (19 is clear, so 18) returns ~A, sets C and updates Z, N, V=0 and S (mask 0x1F).
- R9: Word add (25) and word subtract (26) apply B[5:0] to {pair_hi, A}. They return the low byte on the result port and the high byte on the high-result port, and update C, Z, N, V and S from the 16-bit result (mask 0x1F).
- R10: A word operation whose destination index is not 24, 26, 28 or 30 raises the pair-error output, passes A and pair_hi through unchanged, drives mask 0x00 and leaves the status register unchanged.
- R11: Flag set (27) and flag clear (28) write the single status bit selected by B[2:0] to 1 or 0, and the mask is that bit alone.
- R12: The flag-update mask output equals the masks stated in R2 to R11 for the operation being presented.
- R13: Negate (11) returns 0 - A. C is set when the result is non-zero, and H is the borrow from bit 3. Negating 0x80 returns 0x80 with V and N set (mask 0x3F).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; status register updates on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_i | input | 5 | Operation code |
| opa_i | input | 8 | Destination operand (low byte for word operations) |
| opb_i | input | 8 | Source operand, immediate, or flag bit selector |
| pair_hi_i | input | 8 | High byte of the register pair for word operations |
| dst_idx_i | input | 5 | Index of the destination register |
| res_o | output | 8 | Value to write back |
| res_hi_o | output | 8 | High byte to write back for word operations |
| flag_mask_o | output | 8 | Status bits updated by the current operation |
| status_o | output | 8 | Registered status register |
| pair_err_o | output | 1 | Word operation aimed at a register that is not a permitted pair |

## Verification
The hardest state to reach is a chained subtract in which the zero flag is held across bytes. It needs Z already set by an earlier operation and then a zero difference that includes the incoming carry. Random operands seldom produce that pairing. The directed part therefore sets Z with a flag-set operation, runs subtract with carry and compare with carry on equal operands with carry both clear and set, and then on operands that differ, so that both the held and the cleared case occur. Word operations at the 0xFFFF and 0x0000 boundaries, together with destination indices that are odd or outside the pair range, are also driven directly.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

   localparam int NUM_FLAGS = 8;
   localparam int FL_C = 0;
   localparam int FL_Z = 1;
   localparam int FL_N = 2;
   localparam int FL_V = 3;
   localparam int FL_S = 4;
   localparam int FL_H = 5;
   localparam int FL_T = 6;
   localparam int FL_I = 7;

   typedef enum logic [4:0] {
      OP_NOP   = 5'd0,
      OP_COPY  = 5'd1,
      OP_LOADK = 5'd2,
      OP_FILL  = 5'd3,
      OP_NSWAP = 5'd4,
      OP_ADD   = 5'd5,
      OP_ADDC  = 5'd6,
      OP_SUB   = 5'd7,
      OP_SUBC  = 5'd8,
      OP_CMP   = 5'd9,
      OP_CMPC  = 5'd10,
      OP_NEG   = 5'd11,
      OP_INC   = 5'd12,
      OP_DEC   = 5'd13,
      OP_AND   = 5'd14,
      OP_OR    = 5'd15,
      OP_XOR   = 5'd16,
      OP_TEST  = 5'd17,
      OP_INV   = 5'd18,
      OP_ZERO  = 5'd19,
      OP_SHL   = 5'd20,
      OP_SHR   = 5'd21,
      OP_ROLC  = 5'd22,
      OP_RORC  = 5'd23,
      OP_SAR   = 5'd24,
      OP_WADD  = 5'd25,
      OP_WSUB  = 5'd26,
      OP_FSET  = 5'd27,
      OP_FCLR  = 5'd28
   } alu_op_e;

   typedef enum logic [1:0] {
      CLS_NONE  = 2'd0,
      CLS_ARITH = 2'd1,
      CLS_LOGIC = 2'd2,
      CLS_WORD  = 2'd3
   } op_class_e;

   function automatic logic [NUM_FLAGS-1:0] flag_mask(input logic [4:0] op,
                                                      input logic [2:0] bsel);
      logic [NUM_FLAGS-1:0] m;
      m = '0;
      case (op)
         OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP, OP_CMPC, OP_NEG,
         OP_SHL, OP_ROLC:                         m = 8'h3F;
         OP_INC, OP_DEC, OP_AND, OP_OR, OP_XOR,
         OP_TEST, OP_ZERO:                        m = 8'h1E;
         OP_INV, OP_SHR, OP_RORC, OP_SAR,
         OP_WADD, OP_WSUB:                        m = 8'h1F;
         OP_FSET, OP_FCLR:                        m = 8'(1) << bsel;
         default:                                 m = '0;
      endcase
      return m;
   endfunction

   function automatic op_class_e op_class(input logic [4:0] op);
      op_class_e k;
      case (op)
         OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP, OP_CMPC,
         OP_NEG, OP_INC, OP_DEC:                  k = CLS_ARITH;
         OP_WADD, OP_WSUB:                        k = CLS_WORD;
         OP_FSET, OP_FCLR:                        k = CLS_NONE;
         default:                                 k = CLS_LOGIC;
      endcase
      return k;
   endfunction

endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
   parameter int W      = 8,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] y_i,
   input  logic         cin_i,
   output logic [W-1:0] sum_o,
   output logic         c_nib_o,
   output logic         c_out_o
);

   if (W < 5) begin : g_bad_width
      $error("alu8_adder: W must be at least 5");
   end

   if (RIPPLE) begin : g_ripple
      logic [W:0] cy;
      assign cy[0] = cin_i;
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign sum_o[i]  = x_i[i] ^ y_i[i] ^ cy[i];
         assign cy[i+1]   = (x_i[i] & y_i[i]) | (x_i[i] & cy[i]) | (y_i[i] & cy[i]);
      end
      assign c_nib_o = cy[4];
      assign c_out_o = cy[W];
   end else begin : g_flat
      logic [W:0] full;
      logic [4:0] low;
      assign full    = {1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, cin_i};
      assign low     = {1'b0, x_i[3:0]} + {1'b0, y_i[3:0]} + {4'b0, cin_i};
      assign sum_o   = full[W-1:0];
      assign c_out_o = full[W];
      assign c_nib_o = low[4];
   end

endmodule

// File: rtl/alu8_arith.sv
module alu8_arith
   import alu8_pkg::*;
#(
   parameter int W      = 8,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [4:0]           op_i,
   input  logic [W-1:0]         a_i,
   input  logic [W-1:0]         b_i,
   input  logic                 c_in_i,
   input  logic                 z_in_i,
   output logic [W-1:0]         res_o,
   output logic [NUM_FLAGS-1:0] flags_o
);

   localparam int MSB = W - 1;

   logic [W-1:0] x, y, sum;
   logic         cin, borrow_mode, c_nib, c_out;
   logic         fc, fz, fn, fv, fh;

   always_comb begin
      x           = a_i;
      y           = b_i;
      cin         = 1'b0;
      borrow_mode = 1'b0;
      case (op_i)
         OP_ADDC: cin = c_in_i;
         OP_SUB, OP_CMP: begin
            y = ~b_i; cin = 1'b1; borrow_mode = 1'b1;
         end
         OP_SUBC, OP_CMPC: begin
            y = ~b_i; cin = ~c_in_i; borrow_mode = 1'b1;
         end
         OP_NEG: begin
            x = '0; y = ~a_i; cin = 1'b1; borrow_mode = 1'b1;
         end
         OP_INC: begin
            y = '0; cin = 1'b1;
         end
         OP_DEC: begin
            y = '1; cin = 1'b0;
         end
         default: ;
      endcase
   end

   alu8_adder #(.W(W), .RIPPLE(RIPPLE)) adder_i (
      .x_i     (x),
      .y_i     (y),
      .cin_i   (cin),
      .sum_o   (sum),
      .c_nib_o (c_nib),
      .c_out_o (c_out)
   );

   always_comb begin
      fc = borrow_mode ? ~c_out : c_out;
      fh = borrow_mode ? ~c_nib : c_nib;
      fn = sum[MSB];
      fv = (x[MSB] & y[MSB] & ~sum[MSB]) | (~x[MSB] & ~y[MSB] & sum[MSB]);
      if (op_i == OP_SUBC || op_i == OP_CMPC)
         fz = (sum == '0) & z_in_i;
      else
         fz = (sum == '0);
      flags_o       = '0;
      flags_o[FL_C] = fc;
      flags_o[FL_Z] = fz;
      flags_o[FL_N] = fn;
      flags_o[FL_V] = fv;
      flags_o[FL_S] = fn ^ fv;
      flags_o[FL_H] = fh;
      res_o = (op_i == OP_CMP || op_i == OP_CMPC) ? a_i : sum;
   end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
   import alu8_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [4:0]           op_i,
   input  logic [W-1:0]         a_i,
   input  logic [W-1:0]         b_i,
   input  logic                 c_in_i,
   output logic [W-1:0]         res_o,
   output logic [NUM_FLAGS-1:0] flags_o
);

   localparam int MSB  = W - 1;
   localparam int HALF = W / 2;

   if ((W % 2) != 0) begin : g_bad_width
      $error("alu8_logic: W must be even for the half swap");
   end

   logic [W-1:0] r;
   logic         fc, fv, shift_op;

   always_comb begin
      r        = a_i;
      fc       = c_in_i;
      shift_op = 1'b0;
      case (op_i)
         OP_COPY, OP_LOADK: r = b_i;
         OP_FILL:           r = '1;
         OP_NSWAP:          r = {a_i[HALF-1:0], a_i[W-1:HALF]};
         OP_AND:            r = a_i & b_i;
         OP_OR:             r = a_i | b_i;
         OP_XOR:            r = a_i ^ b_i;
         OP_ZERO:           r = a_i ^ a_i;
         OP_TEST:           r = a_i;
         OP_INV: begin
            r  = ~a_i;
            fc = 1'b1;
         end
         OP_SHL: begin
            r = {a_i[W-2:0], 1'b0}; fc = a_i[MSB]; shift_op = 1'b1;
         end
         OP_ROLC: begin
            r = {a_i[W-2:0], c_in_i}; fc = a_i[MSB]; shift_op = 1'b1;
         end
         OP_SHR: begin
            r = {1'b0, a_i[W-1:1]}; fc = a_i[0]; shift_op = 1'b1;
         end
         OP_RORC: begin
            r = {c_in_i, a_i[W-1:1]}; fc = a_i[0]; shift_op = 1'b1;
         end
         OP_SAR: begin
            r = {a_i[MSB], a_i[W-1:1]}; fc = a_i[0]; shift_op = 1'b1;
         end
         default: r = a_i;
      endcase
      fv            = shift_op ? (r[MSB] ^ fc) : 1'b0;
      flags_o       = '0;
      flags_o[FL_C] = fc;
      flags_o[FL_Z] = (r == '0);
      flags_o[FL_N] = r[MSB];
      flags_o[FL_V] = fv;
      flags_o[FL_S] = r[MSB] ^ fv;
      flags_o[FL_H] = a_i[3];
      res_o         = r;
   end

endmodule

// File: rtl/alu8_word.sv
module alu8_word
   import alu8_pkg::*;
#(
   parameter int W         = 8,
   parameter int IMM_W     = 6,
   parameter int IDX_W     = 5,
   parameter int PAIR_BASE = 24,
   parameter int PAIR_NUM  = 4
) (
   input  logic                 sub_i,
   input  logic [W-1:0]         lo_i,
   input  logic [W-1:0]         hi_i,
   input  logic [IMM_W-1:0]     imm_i,
   input  logic [IDX_W-1:0]     idx_i,
   output logic [W-1:0]         res_lo_o,
   output logic [W-1:0]         res_hi_o,
   output logic                 legal_o,
   output logic [NUM_FLAGS-1:0] flags_o
);

   localparam int WW  = 2 * W;
   localparam int TOP = WW - 1;

   if (IMM_W >= WW) begin : g_bad_imm
      $error("alu8_word: immediate must be narrower than the pair");
   end
   if (PAIR_BASE + 2 * PAIR_NUM > (1 << IDX_W)) begin : g_bad_pairs
      $error("alu8_word: pair range exceeds the register index space");
   end

   logic [PAIR_NUM-1:0] hit;
   for (genvar g = 0; g < PAIR_NUM; g++) begin : g_pair
      assign hit[g] = (idx_i == IDX_W'(PAIR_BASE + 2 * g));
   end
   assign legal_o = |hit;

   logic [WW-1:0] src, ext, w;
   logic          fn, fv, fc;

   always_comb begin
      src = {hi_i, lo_i};
      ext = {{(WW-IMM_W){1'b0}}, imm_i};
      w   = sub_i ? (src - ext) : (src + ext);
      fn  = w[TOP];
      if (sub_i) begin
         fv = src[TOP] & ~w[TOP];
         fc = w[TOP] & ~src[TOP];
      end else begin
         fv = ~src[TOP] & w[TOP];
         fc = src[TOP] & ~w[TOP];
      end
      flags_o       = '0;
      flags_o[FL_C] = fc;
      flags_o[FL_Z] = (w == '0);
      flags_o[FL_N] = fn;
      flags_o[FL_V] = fv;
      flags_o[FL_S] = fn ^ fv;
      res_lo_o      = w[W-1:0];
      res_hi_o      = w[WW-1:W];
   end

endmodule

// File: rtl/alu8_status.sv
module alu8_status
   import alu8_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_FLAGS-1:0] upd_mask_i,
   input  logic [NUM_FLAGS-1:0] upd_val_i,
   output logic [NUM_FLAGS-1:0] status_o
);

   logic [NUM_FLAGS-1:0] sreg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sreg_q <= '0;
      else
         sreg_q <= (sreg_q & ~upd_mask_i) | (upd_val_i & upd_mask_i);
   end

   assign status_o = sreg_q;

   // S tracks N xor V whenever an operation rewrote all three
   assert_signed_test_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_mask_i[FL_N] && upd_mask_i[FL_V] && upd_mask_i[FL_S]) |=>
      (status_o[FL_S] == (status_o[FL_N] ^ status_o[FL_V])));

endmodule

// File: rtl/alu8_core.sv
module alu8_core
   import alu8_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int IMM_W     = 6,
   parameter int IDX_W     = 5,
   parameter int PAIR_BASE = 24,
   parameter int PAIR_NUM  = 4,
   parameter bit RIPPLE    = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [4:0]           op_i,
   input  logic [DATA_W-1:0]    opa_i,
   input  logic [DATA_W-1:0]    opb_i,
   input  logic [DATA_W-1:0]    pair_hi_i,
   input  logic [IDX_W-1:0]     dst_idx_i,
   output logic [DATA_W-1:0]    res_o,
   output logic [DATA_W-1:0]    res_hi_o,
   output logic [NUM_FLAGS-1:0] flag_mask_o,
   output logic [NUM_FLAGS-1:0] status_o,
   output logic                 pair_err_o
);

   localparam int MSB = DATA_W - 1;

   if (DATA_W < 8) begin : g_bad_data
      $error("alu8_core: DATA_W must be at least 8");
   end
   if (IMM_W > DATA_W) begin : g_bad_imm
      $error("alu8_core: IMM_W must fit in the source operand");
   end

   logic [DATA_W-1:0]    ar_res, lg_res, wd_lo, wd_hi;
   logic [NUM_FLAGS-1:0] ar_flags, lg_flags, wd_flags;
   logic [NUM_FLAGS-1:0] upd_val, upd_mask;
   logic                 wd_legal, is_word;
   op_class_e            cls;

   alu8_arith #(.W(DATA_W), .RIPPLE(RIPPLE)) arith_i (
      .op_i    (op_i),
      .a_i     (opa_i),
      .b_i     (opb_i),
      .c_in_i  (status_o[FL_C]),
      .z_in_i  (status_o[FL_Z]),
      .res_o   (ar_res),
      .flags_o (ar_flags)
   );

   alu8_logic #(.W(DATA_W)) logic_i (
      .op_i    (op_i),
      .a_i     (opa_i),
      .b_i     (opb_i),
      .c_in_i  (status_o[FL_C]),
      .res_o   (lg_res),
      .flags_o (lg_flags)
   );

   alu8_word #(
      .W         (DATA_W),
      .IMM_W     (IMM_W),
      .IDX_W     (IDX_W),
      .PAIR_BASE (PAIR_BASE),
      .PAIR_NUM  (PAIR_NUM)
   ) word_i (
      .sub_i    (op_i == OP_WSUB),
      .lo_i     (opa_i),
      .hi_i     (pair_hi_i),
      .imm_i    (opb_i[IMM_W-1:0]),
      .idx_i    (dst_idx_i),
      .res_lo_o (wd_lo),
      .res_hi_o (wd_hi),
      .legal_o  (wd_legal),
      .flags_o  (wd_flags)
   );

   always_comb begin
      cls        = op_class(op_i);
      is_word    = (cls == CLS_WORD);
      pair_err_o = is_word & ~wd_legal;
      upd_mask   = pair_err_o ? '0 : flag_mask(op_i, opb_i[2:0]);
      res_o      = opa_i;
      res_hi_o   = pair_hi_i;
      upd_val    = '0;
      case (cls)
         CLS_ARITH: begin
            res_o   = ar_res;
            upd_val = ar_flags;
         end
         CLS_LOGIC: begin
            res_o   = lg_res;
            upd_val = lg_flags;
         end
         CLS_WORD: begin
            if (wd_legal) begin
               res_o    = wd_lo;
               res_hi_o = wd_hi;
            end
            upd_val = wd_flags;
         end
         default: upd_val = (op_i == OP_FSET) ? '1 : '0;
      endcase
   end

   assign flag_mask_o = upd_mask;

   alu8_status status_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .upd_mask_i (upd_mask),
      .upd_val_i  (upd_val),
      .status_o   (status_o)
   );

   // chained subtract never raises Z
   assert_sticky_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((op_i == OP_SUBC || op_i == OP_CMPC) && !status_o[FL_Z]) |=> !status_o[FL_Z]);

   // data movement keeps the whole status register
   assert_moves_keep_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_COPY || op_i == OP_LOADK || op_i == OP_FILL ||
       op_i == OP_NSWAP || op_i == OP_NOP) |=> $stable(status_o));

   // rejected pair operation leaves status alone
   assert_bad_pair_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pair_err_o |=> $stable(status_o));

   // single-bit set lands in the selected position
   assert_flag_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_FSET) |=> status_o[$past(opb_i[2:0])]);

   // negating the most negative value overflows and keeps it
   assert_neg_limit_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_NEG && opa_i == {1'b1, {MSB{1'b0}}}) |->
      (res_o == opa_i && ar_flags[FL_V] && flag_mask_o[FL_V]));

endmodule

// File: tb/alu8_core_tb_top.sv
module alu8_core_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] op_i = 5'd0;
   logic [7:0] opa_i = 8'h00, opb_i = 8'h00, pair_hi_i = 8'h00;
   logic [4:0] dst_idx_i = 5'd0;
   logic [7:0] res_o, res_hi_o, flag_mask_o, status_o;
   logic       pair_err_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   logic [7:0] m_sreg = 8'h00;

   always #10 clk = ~clk;

   alu8_core dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .op_i        (op_i),
      .opa_i       (opa_i),
      .opb_i       (opb_i),
      .pair_hi_i   (pair_hi_i),
      .dst_idx_i   (dst_idx_i),
      .res_o       (res_o),
      .res_hi_o    (res_hi_o),
      .flag_mask_o (flag_mask_o),
      .status_o    (status_o),
      .pair_err_o  (pair_err_o)
   );

   function automatic string req_of(input logic [4:0] op);
      case (op)
         5'd0, 5'd1, 5'd2, 5'd3:        return "R4";
         5'd4:                          return "R6";
         5'd5, 5'd6, 5'd7, 5'd9,
         5'd12, 5'd13:                  return "R2";
         5'd8, 5'd10:                   return "R3";
         5'd11:                         return "R13";
         5'd14, 5'd15, 5'd16, 5'd17,
         5'd18:                         return "R8";
         5'd19:                         return "R7";
         5'd20, 5'd21, 5'd22, 5'd23,
         5'd24:                         return "R5";
         5'd25, 5'd26:                  return "R9";
         5'd27, 5'd28:                  return "R11";
         default:                       return "R4";
      endcase
   endfunction

   function automatic void model(input logic [4:0] op, input logic [7:0] a, b, hi,
                                 input logic [4:0] idx, input logic [7:0] s,
                                 output logic [7:0] r, output logic [7:0] rh,
                                 output logic [7:0] m, output logic [7:0] ns,
                                 output logic err);
      logic c, z, n, v, h, ci;
      logic [7:0] d;
      logic [8:0] t;
      logic [16:0] w;
      int bi;
      c = s[0]; z = s[1]; n = s[2]; v = s[3]; h = s[5];
      ci = s[0];
      r = a; rh = hi; m = 8'h00; err = 1'b0; ns = s;
      case (op)
         5'd1, 5'd2: r = b;
         5'd3:       r = 8'hFF;
         5'd4:       r = {a[3:0], a[7:4]};
         5'd5, 5'd6: begin
            t = {1'b0, a} + {1'b0, b} + {8'd0, (op == 5'd6) & ci};
            r = t[7:0]; c = t[8];
            h = ({1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'd0, (op == 5'd6) & ci}) > 5'd15;
            v = (a[7] == b[7]) && (r[7] != a[7]);
            n = r[7]; z = (r == 0); m = 8'h3F;
         end
         5'd7, 5'd8, 5'd9, 5'd10: begin
            bi = int'(b) + ((op == 5'd8 || op == 5'd10) ? int'(ci) : 0);
            d = 8'(int'(a) - bi);
            c = int'(a) < bi;
            h = int'(a[3:0]) < (int'(b[3:0]) + ((op == 5'd8 || op == 5'd10) ? int'(ci) : 0));
            v = (a[7] != b[7]) && (d[7] != a[7]);
            n = d[7];
            z = (op == 5'd8 || op == 5'd10) ? ((d == 0) && s[1]) : (d == 0);
            m = 8'h3F;
            r = (op == 5'd9 || op == 5'd10) ? a : d;
         end
         5'd11: begin
            r = 8'(0 - int'(a)); c = (a != 0); h = (a[3:0] != 0);
            v = (a == 8'h80); n = r[7]; z = (r == 0); m = 8'h3F;
         end
         5'd12: begin r = a + 8'd1; v = (a == 8'h7F); n = r[7]; z = (r == 0); m = 8'h1E; end
         5'd13: begin r = a - 8'd1; v = (a == 8'h80); n = r[7]; z = (r == 0); m = 8'h1E; end
         5'd14, 5'd15, 5'd16, 5'd17, 5'd19: begin
            if (op == 5'd14) r = a & b;
            else if (op == 5'd15) r = a | b;
            else if (op == 5'd16) r = a ^ b;
            else if (op == 5'd17) r = a;
            else r = 8'h00;
            v = 1'b0; n = r[7]; z = (r == 0); m = 8'h1E;
         end
         5'd18: begin r = ~a; c = 1'b1; v = 1'b0; n = r[7]; z = (r == 0); m = 8'h1F; end
         5'd20, 5'd22: begin
            r = {a[6:0], (op == 5'd22) ? ci : 1'b0};
            c = a[7]; h = a[3]; n = r[7]; z = (r == 0); v = n ^ c; m = 8'h3F;
         end
         5'd21, 5'd23, 5'd24: begin
            if (op == 5'd21) r = {1'b0, a[7:1]};
            else if (op == 5'd23) r = {ci, a[7:1]};
            else r = {a[7], a[7:1]};
            c = a[0]; n = r[7]; z = (r == 0); v = n ^ c; m = 8'h1F;
         end
         5'd25, 5'd26: begin
            if (!(idx == 5'd24 || idx == 5'd26 || idx == 5'd28 || idx == 5'd30)) begin
               err = 1'b1;
            end else begin
               if (op == 5'd25) begin
                  w = {1'b0, hi, a} + {11'd0, b[5:0]};
                  c = w[16]; v = !hi[7] && w[15];
               end else begin
                  w = {1'b0, hi, a} - {11'd0, b[5:0]};
                  c = {hi, a} < {10'd0, b[5:0]}; v = hi[7] && !w[15];
               end
               r = w[7:0]; rh = w[15:8]; n = w[15]; z = (w[15:0] == 0); m = 8'h1F;
            end
         end
         default: ;
      endcase
      if (op == 5'd27 || op == 5'd28) begin
         m = 8'h01 << b[2:0];
         ns = (op == 5'd27) ? (s | m) : (s & ~m);
      end else begin
         ns = (s & ~m) | ({s[7], s[6], h, n ^ v, v, n, z, c} & m);
      end
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act, exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic apply(input logic [4:0] op, input logic [7:0] a, b, hi, input logic [4:0] idx);
      logic [7:0] er, erh, em, ens;
      logic ee;
      string rq;
      @(negedge clk);
      op_i = op; opa_i = a; opb_i = b; pair_hi_i = hi; dst_idx_i = idx;
      model(op, a, b, hi, idx, m_sreg, er, erh, em, ens, ee);
      rq = ee ? "R10" : req_of(op);
      #2;
      chk(rq, "result", 32'(res_o), 32'(er));
      chk(rq, "result_hi", 32'(res_hi_o), 32'(erh));
      chk("R12", "mask", 32'(flag_mask_o), 32'(em));
      chk("R10", "pair_err", 32'(pair_err_o), 32'(ee));
      @(posedge clk);
      #2;
      chk(rq, "status", 32'(status_o), 32'(ens));
      m_sreg = ens;
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20417));
      repeat (3) @(posedge clk);
      @(negedge clk);
      #2;
      chk("R1", "reset status", 32'(status_o), 32'h0);
      rst_n = 1'b1;
      @(posedge clk);
      #2;
      chk("R1", "status after release", 32'(status_o), 32'h0);

      // R11 set and clear individual bits
      for (int i = 0; i < 8; i++) apply(5'd27, 8'h00, 8'(i), 8'h00, 5'd0);
      for (int i = 0; i < 8; i += 2) apply(5'd28, 8'h00, 8'(i), 8'h00, 5'd0);
      // R4 data moves with flags 0xAA present
      apply(5'd1, 8'h12, 8'h00, 8'h00, 5'd0);
      apply(5'd2, 8'h12, 8'h80, 8'h00, 5'd0);
      apply(5'd3, 8'h12, 8'h00, 8'h00, 5'd0);
      apply(5'd0, 8'h00, 8'h00, 8'h00, 5'd0);
      apply(5'd31, 8'h55, 8'h00, 8'h00, 5'd0);
      // R6 swap
      apply(5'd4, 8'h3C, 8'h00, 8'h00, 5'd0);
      apply(5'd4, 8'hA1, 8'h00, 8'h00, 5'd0);
      // R3 sticky zero: set Z, carry clear, equal operands
      apply(5'd28, 8'h00, 8'd0, 8'h00, 5'd0);
      apply(5'd27, 8'h00, 8'd1, 8'h00, 5'd0);
      apply(5'd8, 8'h44, 8'h44, 8'h00, 5'd0);
      apply(5'd27, 8'h00, 8'd0, 8'h00, 5'd0);
      apply(5'd10, 8'h45, 8'h44, 8'h00, 5'd0);
      apply(5'd10, 8'h45, 8'h44, 8'h00, 5'd0);
      apply(5'd8, 8'h10, 8'h20, 8'h00, 5'd0);
      apply(5'd28, 8'h00, 8'd0, 8'h00, 5'd0);
      apply(5'd8, 8'h33, 8'h33, 8'h00, 5'd0);
      // R13 negate corners
      apply(5'd11, 8'h80, 8'h00, 8'h00, 5'd0);
      apply(5'd11, 8'h00, 8'h00, 8'h00, 5'd0);
      apply(5'd11, 8'h01, 8'h00, 8'h00, 5'd0);
      // R2 overflow and half-carry edges
      apply(5'd5, 8'h7F, 8'h01, 8'h00, 5'd0);
      apply(5'd5, 8'h0F, 8'h01, 8'h00, 5'd0);
      apply(5'd7, 8'h80, 8'h01, 8'h00, 5'd0);
      apply(5'd9, 8'h10, 8'h01, 8'h00, 5'd0);
      apply(5'd12, 8'h7F, 8'h00, 8'h00, 5'd0);
      apply(5'd13, 8'h80, 8'h00, 8'h00, 5'd0);
      // R7 clear keeps C and H
      apply(5'd27, 8'h00, 8'd0, 8'h00, 5'd0);
      apply(5'd27, 8'h00, 8'd5, 8'h00, 5'd0);
      apply(5'd19, 8'h9B, 8'h00, 8'h00, 5'd0);
      // R5 rotates through carry
      apply(5'd23, 8'h02, 8'h00, 8'h00, 5'd0);
      apply(5'd22, 8'h80, 8'h00, 8'h00, 5'd0);
      apply(5'd24, 8'h81, 8'h00, 8'h00, 5'd0);
      // R8 complement and test
      apply(5'd18, 8'h00, 8'h00, 8'h00, 5'd0);
      apply(5'd17, 8'h00, 8'h00, 8'h00, 5'd0);
      // R9 word boundaries
      apply(5'd25, 8'hFF, 8'h01, 8'hFF, 5'd24);
      apply(5'd26, 8'h00, 8'h01, 8'h00, 5'd30);
      apply(5'd25, 8'hC1, 8'h3F, 8'h7F, 5'd26);
      apply(5'd26, 8'h05, 8'h3F, 8'h80, 5'd28);
      // R10 illegal pairs
      apply(5'd25, 8'h10, 8'h01, 8'h20, 5'd25);
      apply(5'd26, 8'h10, 8'h01, 8'h20, 5'd22);
      apply(5'd25, 8'h10, 8'h01, 8'h20, 5'd0);

      for (int k = 0; k < 3000; k++) begin
         logic [4:0] rop, ridx;
         rop = 5'($urandom_range(0, 31));
         if ($urandom_range(0, 1) == 0) ridx = 5'(24 + 2 * $urandom_range(0, 3));
         else ridx = 5'($urandom_range(0, 31));
         apply(rop, 8'($urandom), 8'($urandom), 8'($urandom), ridx);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule